// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block loads a configuration image into a target FPGA through its byte-wide slave configuration port. A reset request makes it pulse the target's program line low, wait for the init line to come up, and then accept image bytes from a host through a valid/ready stream. Each byte goes onto the data bus and is clocked in with one configuration-clock pulse. Each clock phase lasts a programmable number of system clocks. The host sends bytes in chunks of up to 64. `in_last` marks the final byte of a chunk. A chunk that closes short of 64 bytes ends the image.

Once the image has ended, the loader issues a long train of trailing clocks so the target can run its start-up sequence. At fixed pulse positions in that train it raises the chip-select/write control line and then stops driving the data bus and the mode pins. Throughout the load it keeps a 32-bit byte count and an 8-bit additive checksum. It also builds a diagnostic code from the init-line level seen at three checkpoints. If the done line is high at the end, it sets a configured flag and emits a one-cycle notification.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After a one-cycle `reset_req`, `prog_n` is low for exactly SETTLE_CYC cycles and then goes high. From then on, `bus_oe` is 1 and `mode_pins` is {flash_mode sampled at the request, 1'b1}.
- R2: After the program pulse the loader samples `init_in` once per cycle. It stops when `init_in` is 1 or after POLL_MAX+1 samples. It then sets `diag_code` to 200 if `init_in` is 1 and to 100 if it is 0, clears `checksum` and `byte_count`, and raises `in_ready`.
- R3: An accepted byte appears on `data_out` in the cycle after the handshake. `cfg_clk` is then low for L cycles and high for L cycles, where L is `phase_len`, or 1 when `phase_len` is 0. `in_ready` stays low until the pulse has ended, and `data_out` does not change while `cfg_clk` is high.
- R4: `checksum` is the sum modulo 256 of every byte accepted since the poll ended.
- R5: `byte_count` is 32 bits wide and grows by the chunk's size when a chunk closes. A chunk closes on a byte with `in_last`=1, or on its 64th byte.
- R6: A chunk that closes on `in_last` with fewer than 64 bytes starts the finish sequence. A chunk of exactly 64 bytes leaves the loader accepting bytes.
- R7: When the finish sequence starts, `diag_code` grows by 20 if `init_in` is 1, or by 10 if it is 0.
- R8: After the last data pulse the loader issues TRAIL_LONG+4 pulses and then sets `sel_ctl` to 1. It issues one more pulse, sets `bus_oe` to 0, and issues 3 final pulses. The total is TRAIL_LONG+8 pulses.
- R9: After the final pulse, `diag_code` grows by 2 if `init_in` is 1, or by 1 if it is 0. If `done_in` is 1, `configured` becomes 1 and `post_cfg` is high for exactly one cycle. Otherwise `configured` stays 0. `busy` then falls.
- R10: `reset_req` in any state aborts the current operation and restarts from R1. This applies even in the cycle of a byte handshake. An aborted byte is neither clocked nor placed on `data_out`, and `configured` is cleared.
- R11: While `rst` is high, `prog_n`=1, `sel_ctl`=1, `bus_oe`=0, `cfg_clk`=0, `in_ready`=0, `busy`=0, `configured`=0 and `diag_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Start (or restart) a configuration |
| flash_mode | input | 1 | Select flash boot source on the extra mode pin |
| phase_len | input | PHASE_W | System clocks per configuration-clock phase (0 means 1) |
| in_valid | input | 1 | Image byte valid |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Last byte of the current chunk |
| in_ready | output | 1 | Loader can take a byte |
| init_in | input | 1 | Target init line level |
| done_in | input | 1 | Target done line level |
| prog_n | output | 1 | Target program line, active low |
| cfg_clk | output | 1 | Configuration clock |
| data_out | output | 8 | Configuration data bus |
| sel_ctl | output | 1 | Chip-select/write control line |
| bus_oe | output | 1 | Drive enable for data bus and mode pins |
| mode_pins | output | 2 | Mode pin values {flash, normal} |
| busy | output | 1 | A configuration sequence is in progress |
| configured | output | 1 | Last finish sequence saw done high |
| post_cfg | output | 1 | One-cycle notice of successful configuration |
| checksum | output | 8 | Running additive checksum |
| byte_count | output | 32 | Bytes in closed chunks |
| diag_code | output | 8 | Init-line diagnostic code |

## Verification
A reset request can arrive in the same cycle as a byte handshake. The bench provokes this by raising `reset_req` and `in_valid` together while `in_ready` is high. It then judges from the ports that the byte was dropped: `data_out` still holds the previous byte, no extra `cfg_clk` rise appears, and the counters restart from zero. A second overlap places the 64th byte of a chunk in the same cycle as `in_last`. Here the chunk close and the end-of-image test meet, and the bench expects the byte count to grow by 64 with the finish sequence not started. A reset request during the trailing clock train is also checked. It must suppress the configured flag and the notification.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int DIAG_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_POLL,
        S_LOAD,
        S_DRAIN,
        S_FIN,
        S_TRAIL,
        S_CHECK
    } ld_state_t;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_LO,
        PG_HI
    } pg_state_t;

    localparam logic [DIAG_W-1:0] DIAG_POLL_HI = 8'd200;
    localparam logic [DIAG_W-1:0] DIAG_POLL_LO = 8'd100;
    localparam logic [DIAG_W-1:0] DIAG_FIN_HI  = 8'd20;
    localparam logic [DIAG_W-1:0] DIAG_FIN_LO  = 8'd10;
    localparam logic [DIAG_W-1:0] DIAG_END_HI  = 8'd2;
    localparam logic [DIAG_W-1:0] DIAG_END_LO  = 8'd1;

    // choose one of two diagnostic weights from the init level
    function automatic logic [DIAG_W-1:0] diag_pick(
        input logic lvl,
        input logic [DIAG_W-1:0] hi,
        input logic [DIAG_W-1:0] lo
    );
        return lvl ? hi : lo;
    endfunction

endpackage

// File: rtl/cfg_pulse_gen.sv
module cfg_pulse_gen
    import cfg_loader_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               abort,
    input  logic               go,
    input  logic [PHASE_W-1:0] phase_len,
    output logic               cclk,
    output logic               idle,
    output logic               fin
);
    pg_state_t          st_q;
    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] len_m1;
    logic               free;

    // a zero length is treated as one cycle per phase
    assign len_m1 = (phase_len == '0) ? '0 : phase_len - 1'b1;
    assign fin    = (st_q == PG_HI) && (cnt_q == '0);
    assign idle   = (st_q == PG_IDLE);
    assign free   = idle || fin;
    assign cclk   = (st_q == PG_HI);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st_q  <= PG_IDLE;
            cnt_q <= '0;
        end else if (free) begin
            if (go) begin
                st_q  <= PG_LO;
                cnt_q <= len_m1;
            end else begin
                st_q  <= PG_IDLE;
            end
        end else if (cnt_q == '0) begin
            st_q  <= PG_HI;
            cnt_q <= len_m1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/cfg_accum.sv
module cfg_accum #(
    parameter int DATA_W    = 8,
    parameter int CHUNK_MAX = 64,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              accept,
    input  logic [DATA_W-1:0] data,
    input  logic              last,
    output logic [DATA_W-1:0] checksum,
    output logic [CNT_W-1:0]  byte_count,
    output logic              short_end
);
    localparam int CW = $clog2(CHUNK_MAX + 1);
    localparam logic [CW-1:0] FULL_IDX = CW'(CHUNK_MAX - 1);

    logic [CW-1:0]     chunk_q;
    logic [DATA_W-1:0] sum_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full;
    logic              close;

    assign full      = (chunk_q == FULL_IDX);
    assign close     = last || full;
    assign short_end = accept && last && !full;
    assign checksum  = sum_q;
    assign byte_count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            chunk_q <= '0;
            sum_q   <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            sum_q <= sum_q + data;
            if (close) begin
                cnt_q   <= cnt_q + CNT_W'(chunk_q) + 1'b1;
                chunk_q <= '0;
            end else begin
                chunk_q <= chunk_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int PHASE_W    = 8,
    parameter int CHUNK_MAX  = 64,
    parameter int SETTLE_CYC = 1000,
    parameter int POLL_MAX   = 65535,
    parameter int TRAIL_LONG = 65535,
    parameter int TRAIL_TAIL = 4,
    parameter int TRAIL_POST = 1,
    parameter int TRAIL_LAST = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reset_req,
    input  logic               flash_mode,
    input  logic [PHASE_W-1:0] phase_len,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    output logic               in_ready,
    input  logic               init_in,
    input  logic               done_in,
    output logic               prog_n,
    output logic               cfg_clk,
    output logic [7:0]         data_out,
    output logic               sel_ctl,
    output logic               bus_oe,
    output logic [1:0]         mode_pins,
    output logic               busy,
    output logic               configured,
    output logic               post_cfg,
    output logic [7:0]         checksum,
    output logic [31:0]        byte_count,
    output logic [DIAG_W-1:0]  diag_code
);
    localparam int N_SEL   = TRAIL_LONG + TRAIL_TAIL;
    localparam int N_REL   = N_SEL + TRAIL_POST;
    localparam int N_TOT   = N_REL + TRAIL_LAST;
    localparam int PW      = $clog2(N_TOT + 1);
    localparam int SW      = $clog2(SETTLE_CYC + 1);
    localparam int QW      = $clog2(POLL_MAX + 1);
    localparam logic [PW-1:0] SEL_AT  = PW'(N_SEL);
    localparam logic [PW-1:0] REL_AT  = PW'(N_REL);
    localparam logic [PW-1:0] TOT_C   = PW'(N_TOT);
    localparam logic [SW-1:0] SET_END = SW'(SETTLE_CYC - 1);
    localparam logic [QW-1:0] POL_END = QW'(POLL_MAX);

    ld_state_t         st_q;
    logic [SW-1:0]     settle_q;
    logic [QW-1:0]     poll_q;
    logic [PW-1:0]     pcnt_q;
    logic [DIAG_W-1:0] diag_q;
    logic              prog_n_q;
    logic              sel_q;
    logic              oe_q;
    logic              flash_q;
    logic              cfg_q;
    logic              post_q;
    logic [7:0]        data_q;

    logic pg_idle;
    logic pg_fin;
    logic pg_free;
    logic pg_go;
    logic accept;
    logic trail_go;
    logic poll_exit;
    logic short_end;

    assign pg_free   = pg_idle || pg_fin;
    assign in_ready  = (st_q == S_LOAD) && pg_idle;
    assign accept    = in_valid && in_ready && !reset_req;
    assign trail_go  = (st_q == S_TRAIL) && pg_free && (pcnt_q != TOT_C);
    assign pg_go     = accept || trail_go;
    assign poll_exit = (st_q == S_POLL) && (init_in || (poll_q == POL_END));

    cfg_pulse_gen #(
        .PHASE_W (PHASE_W)
    ) pulse_i (
        .clk       (clk),
        .rst       (rst),
        .abort     (reset_req),
        .go        (pg_go),
        .phase_len (phase_len),
        .cclk      (cfg_clk),
        .idle      (pg_idle),
        .fin       (pg_fin)
    );

    cfg_accum #(
        .DATA_W    (8),
        .CHUNK_MAX (CHUNK_MAX),
        .CNT_W     (32)
    ) accum_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (poll_exit && !reset_req),
        .accept     (accept),
        .data       (in_data),
        .last       (in_last),
        .checksum   (checksum),
        .byte_count (byte_count),
        .short_end  (short_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            settle_q <= '0;
            poll_q   <= '0;
            pcnt_q   <= '0;
            diag_q   <= '0;
            prog_n_q <= 1'b1;
            sel_q    <= 1'b1;
            oe_q     <= 1'b0;
            flash_q  <= 1'b0;
            cfg_q    <= 1'b0;
            post_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            post_q <= 1'b0;
            if (reset_req) begin
                st_q     <= S_PROG;
                settle_q <= '0;
                prog_n_q <= 1'b0;
                sel_q    <= 1'b1;
                oe_q     <= 1'b0;
                flash_q  <= flash_mode;
                cfg_q    <= 1'b0;
            end else begin
                unique case (st_q)
                    S_IDLE: ;
                    S_PROG: begin
                        if (settle_q == SET_END) begin
                            prog_n_q <= 1'b1;
                            sel_q    <= 1'b0;
                            oe_q     <= 1'b1;
                            poll_q   <= '0;
                            st_q     <= S_POLL;
                        end else begin
                            settle_q <= settle_q + 1'b1;
                        end
                    end
                    S_POLL: begin
                        if (poll_exit) begin
                            diag_q <= diag_pick(init_in, DIAG_POLL_HI, DIAG_POLL_LO);
                            st_q   <= S_LOAD;
                        end else begin
                            poll_q <= poll_q + 1'b1;
                        end
                    end
                    S_LOAD: begin
                        if (accept) begin
                            data_q <= in_data;
                            if (short_end) st_q <= S_DRAIN;
                        end
                    end
                    S_DRAIN: begin
                        if (pg_fin) st_q <= S_FIN;
                    end
                    S_FIN: begin
                        diag_q <= diag_q + diag_pick(init_in, DIAG_FIN_HI, DIAG_FIN_LO);
                        pcnt_q <= '0;
                        st_q   <= S_TRAIL;
                    end
                    S_TRAIL: begin
                        if (trail_go) begin
                            pcnt_q <= pcnt_q + 1'b1;
                            if (pcnt_q == SEL_AT) sel_q <= 1'b1;
                            if (pcnt_q == REL_AT) oe_q  <= 1'b0;
                        end
                        if (pg_fin && (pcnt_q == TOT_C)) st_q <= S_CHECK;
                    end
                    S_CHECK: begin
                        diag_q <= diag_q + diag_pick(init_in, DIAG_END_HI, DIAG_END_LO);
                        if (done_in) begin
                            cfg_q  <= 1'b1;
                            post_q <= 1'b1;
                        end
                        st_q <= S_IDLE;
                    end
                    default: st_q <= S_IDLE;
                endcase
            end
        end
    end

    assign prog_n     = prog_n_q;
    assign data_out   = data_q;
    assign sel_ctl    = sel_q;
    assign bus_oe     = oe_q;
    assign mode_pins  = {flash_q, 1'b1};
    assign busy       = (st_q != S_IDLE);
    assign configured = cfg_q;
    assign post_cfg   = post_q;
    assign diag_code  = diag_q;

endmodule

// File: rtl/fpga_cfg_loader_chk.sv
module fpga_cfg_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       reset_req,
    input logic       in_ready,
    input logic       prog_n,
    input logic       cfg_clk,
    input logic [7:0] data_out,
    input logic       busy,
    input logic       configured,
    input logic       post_cfg
);
    assert_prog_low_R1: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !prog_n);

    assert_ready_gated_R3: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (prog_n && !cfg_clk && busy));

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_clk |-> $stable(data_out));

    assert_post_single_R9: assert property (@(posedge clk) disable iff (rst)
        post_cfg |=> !post_cfg);

    assert_post_cfg_R9: assert property (@(posedge clk) disable iff (rst)
        post_cfg |-> (configured && !busy));

    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> (!configured && !in_ready && busy));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cfg_clk && !in_ready));

endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .reset_req  (reset_req),
    .in_ready   (in_ready),
    .prog_n     (prog_n),
    .cfg_clk    (cfg_clk),
    .data_out   (data_out),
    .busy       (busy),
    .configured (configured),
    .post_cfg   (post_cfg)
);

// File: tb/fpga_cfg_loader_tb.sv
module fpga_cfg_loader_tb_top;
    localparam int SETTLE = 3;
    localparam int POLLM  = 10;
    localparam int TLONG  = 5;
    localparam int NTRAIL = TLONG + 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reset_req = 1'b0;
    logic       flash_mode = 1'b0;
    logic [7:0] phase_len = 8'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_last = 1'b0;
    logic       init_in = 1'b0;
    logic       done_in = 1'b0;
    logic       in_ready, prog_n, cfg_clk, sel_ctl, bus_oe, busy, configured, post_cfg;
    logic [7:0] data_out, checksum, diag_code;
    logic [1:0] mode_pins;
    logic [31:0] byte_count;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    int rise_cnt = 0, lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
    int prog_run = 0, prog_lo_len = 0, ctl_at = -1, oe_at = -1, post_cnt = 0;
    logic cclk_d = 0, prog_d = 1, sel_d = 1, oe_d = 0;

    int exp_cnt = 0;
    int exp_sum = 0;
    int base = 0;

    always #5 clk = ~clk;

    fpga_cfg_loader #(
        .PHASE_W(8), .CHUNK_MAX(64), .SETTLE_CYC(SETTLE), .POLL_MAX(POLLM),
        .TRAIL_LONG(TLONG), .TRAIL_TAIL(4), .TRAIL_POST(1), .TRAIL_LAST(3)
    ) dut_i (
        .clk(clk), .rst(rst), .reset_req(reset_req), .flash_mode(flash_mode),
        .phase_len(phase_len), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .init_in(init_in),
        .done_in(done_in), .prog_n(prog_n), .cfg_clk(cfg_clk),
        .data_out(data_out), .sel_ctl(sel_ctl), .bus_oe(bus_oe),
        .mode_pins(mode_pins), .busy(busy), .configured(configured),
        .post_cfg(post_cfg), .checksum(checksum), .byte_count(byte_count),
        .diag_code(diag_code)
    );

    // port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (cfg_clk && !cclk_d) begin rise_cnt++; last_lo = lo_run; end
            if (!cfg_clk && cclk_d) last_hi = hi_run;
            if (cfg_clk) hi_run = cclk_d ? hi_run + 1 : 1;
            else         lo_run = cclk_d ? 1 : lo_run + 1;
            if (!prog_n) prog_run++;
            if (prog_n && !prog_d) begin prog_lo_len = prog_run; prog_run = 0; end
            if (sel_ctl && !sel_d) ctl_at = rise_cnt;
            if (!bus_oe && oe_d) oe_at = rise_cnt;
            if (post_cfg) post_cnt++;
        end
        cclk_d = cfg_clk; prog_d = prog_n; sel_d = sel_ctl; oe_d = bus_oe;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (in_ready) return;
        end
        chk(0, "ready timeout", 0, 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            if (!busy) return;
        end
        chk(0, "idle timeout", 0, 1);
    endtask

    task automatic request(input logic fm);
        @(negedge clk);
        reset_req = 1'b1; flash_mode = fm;
        @(negedge clk);
        reset_req = 1'b0;
        exp_cnt = 0; exp_sum = 0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic last);
        wait_ready();
        in_valid = 1'b1; in_data = d; in_last = last;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        exp_sum = (exp_sum + d) % 256;
    endtask

    task automatic send_chunk(input int n, input int first, input int step, input bit last);
        for (int i = 0; i < n; i++)
            send_byte(8'((first + i * step) % 256), last && (i == n - 1));
        if (last || n == 64) exp_cnt += n;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(prog_n && sel_ctl && !bus_oe && !cfg_clk && !in_ready && !busy && !configured,
            "R11 reset outputs", {prog_n, sel_ctl, bus_oe, cfg_clk, in_ready, busy, configured}, 7'b1100000);
        check_eq("R11 diag reset", diag_code, 0);
        rst = 1'b0;

        // poll timeout with init low, flash boot
        init_in = 1'b0;
        request(1'b1);
        wait_ready();
        check_eq("R1 program pulse length", prog_lo_len, SETTLE);
        check_eq("R1 flash mode pins", mode_pins, 2'b11);
        check_eq("R1 bus driven", bus_oe, 1);
        check_eq("R2 diag after timeout", diag_code, 100);
        check_eq("R2 count cleared", byte_count, 0);

        // normal boot, init high
        init_in = 1'b1; phase_len = 8'd0;
        request(1'b0);
        wait_ready();
        check_eq("R1 normal mode pins", mode_pins, 2'b01);
        check_eq("R2 diag init high", diag_code, 200);

        // full chunk with in_last on 64th byte
        send_chunk(64, 3, 7, 1);
        wait_ready();
        check_eq("R5 count after full chunk", byte_count, exp_cnt);
        check_eq("R4 checksum full chunk", checksum, exp_sum);
        check_eq("R6 full chunk keeps loading", busy, 1);
        check_eq("R3 zero phase acts as one", last_hi, 1);

        // short chunk ends image, phase 3, done high
        phase_len = 8'd3; done_in = 1'b1;
        base = rise_cnt;
        send_chunk(10, 240, 1, 1);
        wait_idle();
        @(negedge clk);
        check_eq("R5 count after short chunk", byte_count, exp_cnt);
        check_eq("R4 checksum wraps", checksum, exp_sum);
        check_eq("R8 total pulses", rise_cnt - base, 10 + NTRAIL);
        check_eq("R8 control raised", ctl_at, base + 10 + TLONG + 4);
        check_eq("R8 drivers released", oe_at, base + 10 + TLONG + 5);
        check_eq("R7 R9 diag all high", diag_code, 222);
        check_eq("R9 configured", configured, 1);
        check_eq("R9 one notification", post_cnt, 1);
        check_eq("R3 high phase", last_hi, 3);
        check_eq("R3 low phase", last_lo, 3);

        // init low throughout, done low
        init_in = 1'b0; done_in = 1'b0; phase_len = 8'd1;
        request(1'b0);
        wait_ready();
        check_eq("R10 configured cleared", configured, 0);
        send_chunk(5, 17, 33, 1);
        wait_idle();
        @(negedge clk);
        check_eq("R7 R9 diag all low", diag_code, 111);
        check_eq("R9 not configured", configured, 0);
        check_eq("R9 no notification", post_cnt, 1);
        check_eq("R4 checksum low run", checksum, exp_sum);

        // reset request in the same cycle as a handshake
        init_in = 1'b1;
        request(1'b0);
        send_byte(8'h5A, 1'b0);
        wait_ready();
        base = rise_cnt;
        in_valid = 1'b1; in_data = 8'hA5; reset_req = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; reset_req = 1'b0;
        wait_ready();
        check_eq("R10 dropped byte not placed", data_out, 8'h5A);
        check_eq("R10 dropped byte not clocked", rise_cnt, base);
        check_eq("R10 counters restart", byte_count, 0);

        // abort during trailing clocks
        done_in = 1'b1; exp_sum = 0; exp_cnt = 0;
        base = rise_cnt;
        send_chunk(2, 1, 1, 1);
        for (int i = 0; i < 4000 && rise_cnt < base + 6; i++) @(negedge clk);
        request(1'b0);
        wait_ready();
        check_eq("R10 abort no notification", post_cnt, 1);
        check_eq("R10 abort not configured", configured, 0);
        check_eq("R10 abort diag restarts", diag_code, 200);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule